// File: doc/BRIEF.md
# Exception Return Address Selector for a Single-Delay-Slot Pipeline

This block sits at the retire end of a simple in-order pipeline that executes exactly one instruction after every branch (the delay slot). Each cycle the pipeline may offer one retiring instruction on a valid/ready stream. The offer carries the instruction's address, whether it is a branch, the branch direction and target, and whether it raised a synchronous fault. A level-sensitive external interrupt request and a return-from-exception pulse complete the inputs.

When an exception is taken, the block chooses the return address, sets a flag that marks a fault inside a delay slot, pulses an exception strobe and redirects fetch to a fixed handler vector. A fault in a delay slot saves the address of the branch before it, so on return the branch runs again and works out its direction a second time. Interrupts are only taken at boundaries that do not fall between a branch and its slot. The return pulse sends fetch back to the saved address.

Back-pressure on the retire stream: an offer is accepted only in a cycle where both `ret_valid` and `ret_ready` are high. `ret_ready` is low during every redirect cycle and while `eret` is high. The pipeline must hold or flush its offer in those cycles, and an offer made in them has no effect. The block never stalls at any other time.

Top module: `epc_unit`

## Requirements
- R1: An accepted faulting instruction that is not in a delay slot and is not a branch saves its own address in `exc_epc` and clears `exc_in_slot`.
- R2: An accepted faulting instruction in a delay slot (the accepted offer right after an accepted, non-faulting branch) saves the branch's address and sets `exc_in_slot`. The saved state is the same whether the branch was taken or not.
- R3: A fault on a branch saves the branch's address with `exc_in_slot` clear, and the delay slot is dropped: the following cycle has `ret_ready` low.
- R4: `exc_taken` is high for exactly one cycle, the cycle after the accepting clock edge. In that same cycle `redir_valid` is high and `redir_pc` equals HANDLER_VEC.
- R5: `ret_ready` is low in every cycle in which `redir_valid` is high. An offer made then, faulting or not, takes no exception and does not change `exc_epc`.
- R6: An interrupt is never taken on an accepted branch. If the interrupt is present there, it is taken when the delay-slot instruction retires. The saved address is then the branch target if the branch was taken, else the slot address plus INSTR_BYTES, and `exc_in_slot` is clear.
- R7: An interrupt present when a non-branch instruction outside a delay slot retires without a fault lets that instruction complete. It saves that instruction's address plus INSTR_BYTES (modulo 2^PC_W), with `exc_in_slot` clear.
- R8: When a fault and an interrupt arrive on the same accepted offer, the fault is taken and the interrupt stays pending even if the request input drops.
- R9: From exception entry until the `eret` pulse, interrupts are not taken. A pending interrupt is kept, and it is taken at the first eligible retire after `eret`.
- R10: An `eret` pulse gives, in the next cycle, `redir_valid` high with `redir_pc` equal to the saved address, `exc_taken` low and `exc_in_slot` cleared.
- R11: After reset, `exc_taken`, `redir_valid` and `exc_in_slot` are low, `exc_epc` is zero and `ret_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retiring instruction offered |
| ret_ready | output | 1 | Offer can be accepted this cycle |
| ret_pc | input | PC_W | Address of the retiring instruction |
| ret_is_branch | input | 1 | Retiring instruction is a branch |
| ret_taken | input | 1 | Branch direction (1 = taken) |
| ret_target | input | PC_W | Branch target address |
| ret_fault | input | 1 | Retiring instruction raised a synchronous fault |
| irq_req | input | 1 | External interrupt request, level |
| eret | input | 1 | Return from exception |
| exc_taken | output | 1 | One-cycle exception entry strobe, also the flush of younger work |
| exc_epc | output | PC_W | Saved return address |
| exc_in_slot | output | 1 | Saved fault was in a delay slot |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | PC_W | Fetch redirect address |

## Verification
The bench builds the block with PC_W = 16 and HANDLER_VEC = 16'h0100, with INSTR_BYTES left at 4. The narrow address lets a delay slot sit at the top of the address space, so the successor address of an interrupted not-taken slot wraps to zero. The low vector keeps handler-side retires well apart from the branch windows. A reference model sweeps a fault across the branch, the slot and the following instruction for both branch directions. It also covers interrupts held across a slot, the interrupt mask during the handler, and offers made while `ret_ready` is low.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic [1:0] {
    TAKE_NONE  = 2'd0,
    TAKE_FAULT = 2'd1,
    TAKE_IRQ   = 2'd2
  } take_e;
endpackage

// File: rtl/epc_slot_track.sv
module epc_slot_track #(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            kill,
  input  logic [PC_W-1:0] pc,
  input  logic            is_br,
  input  logic            taken,
  input  logic [PC_W-1:0] tgt,
  input  logic            fault,
  output logic            in_slot,
  output logic [PC_W-1:0] br_pc,
  output logic [PC_W-1:0] succ_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic            prev_br_q;
  logic            br_taken_q;
  logic [PC_W-1:0] br_pc_q;
  logic [PC_W-1:0] br_tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_br_q  <= 1'b0;
      br_taken_q <= 1'b0;
      br_pc_q    <= '0;
      br_tgt_q   <= '0;
    end else if (kill) begin
      prev_br_q <= 1'b0;
    end else if (acc) begin
      prev_br_q <= is_br & ~fault;
      if (is_br) begin
        br_taken_q <= taken;
        br_pc_q    <= pc;
        br_tgt_q   <= tgt;
      end
    end
  end

  assign in_slot = prev_br_q;
  assign br_pc   = br_pc_q;
  assign succ_pc = (prev_br_q && br_taken_q) ? br_tgt_q : pc + STEP;
endmodule

// File: rtl/epc_irq_gate.sv
module epc_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic take_any,
  input  logic take_irq,
  input  logic eret,
  output logic irq_live
);
  logic pend_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      pend_q <= (pend_q | irq_req) & ~take_irq;
      if (take_any)  en_q <= 1'b0;
      else if (eret) en_q <= 1'b1;
    end
  end

  assign irq_live = (pend_q | irq_req) & en_q;
endmodule

// File: rtl/epc_decide.sv
module epc_decide
  import epc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            acc,
  input  logic            fault,
  input  logic            is_br,
  input  logic            in_slot,
  input  logic            irq_live,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] br_pc,
  input  logic [PC_W-1:0] succ_pc,
  output take_e           take,
  output logic [PC_W-1:0] save_pc,
  output logic            save_slot
);
  always_comb begin
    take      = TAKE_NONE;
    save_pc   = succ_pc;
    save_slot = 1'b0;
    if (acc && fault) begin
      take      = TAKE_FAULT;
      save_pc   = in_slot ? br_pc : pc;
      save_slot = in_slot;
    end else if (acc && !is_br && irq_live) begin
      take = TAKE_IRQ;
    end
  end
endmodule

// File: rtl/epc_unit.sv
module epc_unit
  import epc_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter int              INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] HANDLER_VEC = PC_W'(128)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  output logic            ret_ready,
  input  logic [PC_W-1:0] ret_pc,
  input  logic            ret_is_branch,
  input  logic            ret_taken,
  input  logic [PC_W-1:0] ret_target,
  input  logic            ret_fault,
  input  logic            irq_req,
  input  logic            eret,
  output logic            exc_taken,
  output logic [PC_W-1:0] exc_epc,
  output logic            exc_in_slot,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  logic            acc;
  logic            in_slot;
  logic [PC_W-1:0] br_pc;
  logic [PC_W-1:0] succ_pc;
  logic            irq_live;
  take_e           take;
  logic            take_any;
  logic            take_irq;
  logic [PC_W-1:0] save_pc;
  logic            save_slot;

  logic            exc_q;
  logic [PC_W-1:0] epc_q;
  logic            slot_q;
  logic            redir_q;
  logic [PC_W-1:0] rpc_q;

  assign ret_ready = ~redir_q & ~eret;
  assign acc       = ret_valid & ret_ready;
  assign take_any  = (take != TAKE_NONE);
  assign take_irq  = (take == TAKE_IRQ);

  epc_slot_track #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .kill    (eret | (take == TAKE_FAULT)),
    .pc      (ret_pc),
    .is_br   (ret_is_branch),
    .taken   (ret_taken),
    .tgt     (ret_target),
    .fault   (ret_fault),
    .in_slot (in_slot),
    .br_pc   (br_pc),
    .succ_pc (succ_pc)
  );

  epc_irq_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .take_any (take_any),
    .take_irq (take_irq),
    .eret     (eret),
    .irq_live (irq_live)
  );

  epc_decide #(.PC_W(PC_W)) u_decide (
    .acc       (acc),
    .fault     (ret_fault),
    .is_br     (ret_is_branch),
    .in_slot   (in_slot),
    .irq_live  (irq_live),
    .pc        (ret_pc),
    .br_pc     (br_pc),
    .succ_pc   (succ_pc),
    .take      (take),
    .save_pc   (save_pc),
    .save_slot (save_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q   <= 1'b0;
      epc_q   <= '0;
      slot_q  <= 1'b0;
      redir_q <= 1'b0;
      rpc_q   <= '0;
    end else begin
      exc_q   <= take_any;
      redir_q <= take_any | eret;
      if (take_any) begin
        epc_q  <= save_pc;
        slot_q <= save_slot;
        rpc_q  <= HANDLER_VEC;
      end else if (eret) begin
        slot_q <= 1'b0;
        rpc_q  <= epc_q;
      end
    end
  end

  assign exc_taken   = exc_q;
  assign exc_epc     = epc_q;
  assign exc_in_slot = slot_q;
  assign redir_valid = redir_q;
  assign redir_pc    = rpc_q;
endmodule

// File: rtl/epc_unit_chk.sv
module epc_unit_chk #(
  parameter int              PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic            ret_ready,
  input logic            ret_is_branch,
  input logic            ret_fault,
  input logic            eret,
  input logic            exc_taken,
  input logic [PC_W-1:0] exc_epc,
  input logic            exc_in_slot,
  input logic            redir_valid,
  input logic [PC_W-1:0] redir_pc
);
  assert_fault_enters_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_fault) |=> exc_taken);

  assert_slot_flag_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_in_slot) |-> exc_taken);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> !exc_taken);

  assert_vector_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (redir_valid && redir_pc == HANDLER_VEC));

  assert_no_accept_on_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !ret_ready);

  assert_no_irq_on_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_is_branch && !ret_fault) |=> !exc_taken);

  assert_eret_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eret |=> (redir_valid && !exc_taken && !exc_in_slot && redir_pc == $past(exc_epc)));
endmodule

bind epc_unit epc_unit_chk #(.PC_W(PC_W), .HANDLER_VEC(HANDLER_VEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_valid     (ret_valid),
  .ret_ready     (ret_ready),
  .ret_is_branch (ret_is_branch),
  .ret_fault     (ret_fault),
  .eret          (eret),
  .exc_taken     (exc_taken),
  .exc_epc       (exc_epc),
  .exc_in_slot   (exc_in_slot),
  .redir_valid   (redir_valid),
  .redir_pc      (redir_pc)
);

// File: tb/test_epc_unit.sv
module test_epc_unit;
  localparam int         CLK_PERIOD = 10;
  localparam int         W   = 16;
  localparam logic [W-1:0] VEC = 16'h0100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ret_valid = 1'b0, ret_is_branch = 1'b0, ret_taken = 1'b0, ret_fault = 1'b0;
  logic [W-1:0] ret_pc = '0, ret_target = '0;
  logic         irq_req = 1'b0, eret = 1'b0;
  logic         ret_ready, exc_taken, exc_in_slot, redir_valid;
  logic [W-1:0] exc_epc, redir_pc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit           is_eret;
    logic [W-1:0] epc;
    bit           slot;
    string        tag;
  } exp_t;
  exp_t sb[$];

  bit           m_prev = 0, m_taken = 0, m_en = 1, m_pend = 0, m_block = 0;
  logic [W-1:0] m_brpc = '0, m_tgt = '0, m_epc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epc_unit #(.PC_W(W), .INSTR_BYTES(4), .HANDLER_VEC(VEC)) i_epc_unit (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_pc(ret_pc), .ret_is_branch(ret_is_branch), .ret_taken(ret_taken),
    .ret_target(ret_target), .ret_fault(ret_fault), .irq_req(irq_req), .eret(eret),
    .exc_taken(exc_taken), .exc_epc(exc_epc), .exc_in_slot(exc_in_slot),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops the scoreboard whenever the design announces an entry or a return.
  always @(negedge clk) begin
    if (rst_n && (exc_taken || redir_valid)) begin
      if (sb.size() == 0) begin
        chk(0, "unexpected event R5/R6/R9", {15'd0, exc_taken}, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.is_eret) begin
          chk(!exc_taken && redir_valid, {e.tag, " eret kind"}, {15'd0, exc_taken}, '0);
          chk(redir_pc == e.epc, {e.tag, " eret redirect"}, redir_pc, e.epc);
          chk(!exc_in_slot, {e.tag, " slot cleared"}, {15'd0, exc_in_slot}, '0);
        end else begin
          chk(exc_taken, {e.tag, " entry kind"}, {15'd0, exc_taken}, 16'd1);
          chk(exc_epc == e.epc, {e.tag, " epc"}, exc_epc, e.epc);
          chk(exc_in_slot == e.slot, {e.tag, " slot flag"}, {15'd0, exc_in_slot}, {15'd0, e.slot});
          chk(redir_valid && redir_pc == VEC, "R4 vector", redir_pc, VEC);
          chk(!ret_ready, "R5 ready low", {15'd0, ret_ready}, '0);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    ret_valid = 0; ret_fault = 0; ret_is_branch = 0; ret_taken = 0; irq_req = 0; eret = 0;
    m_block = 0;
    @(posedge clk);
  endtask

  task automatic retire(input logic [W-1:0] pc, input bit br, input bit tk,
                        input logic [W-1:0] tgt, input bit flt, input bit irq, input string tag);
    bit slot, act;
    exp_t e;
    @(negedge clk);
    ret_valid = 1; ret_pc = pc; ret_is_branch = br; ret_taken = tk; ret_target = tgt;
    ret_fault = flt; irq_req = irq; eret = 0;
    if (m_block) begin
      m_block = 0;
      m_pend = m_pend | irq;
    end else begin
      slot = m_prev;
      act  = m_pend | irq;
      if (flt) begin
        e = '{0, slot ? m_brpc : pc, slot, tag};
        sb.push_back(e);
        m_epc = e.epc; m_en = 0; m_prev = 0; m_pend = act; m_block = 1;
      end else if (act && m_en && !br) begin
        e = '{0, (slot && m_taken) ? m_tgt : pc + 16'd4, 0, tag};
        sb.push_back(e);
        m_epc = e.epc; m_en = 0; m_prev = 0; m_pend = 0; m_block = 1;
      end else begin
        m_pend = act;
        m_prev = br;
        if (br) begin m_brpc = pc; m_taken = tk; m_tgt = tgt; end
      end
    end
    @(posedge clk);
  endtask

  task automatic do_eret();
    exp_t e;
    @(negedge clk);
    ret_valid = 0; ret_fault = 0; irq_req = 0; eret = 1;
    e = '{1, m_epc, 0, "R10"};
    sb.push_back(e);
    m_en = 1; m_prev = 0; m_block = 1;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!exc_taken && !redir_valid && !exc_in_slot, "R11 reset outputs", {15'd0, exc_taken}, '0);
    chk(exc_epc == '0 && ret_ready, "R11 reset epc/ready", exc_epc, '0);
    rst_n = 1;
    @(posedge clk);

    // R1: plain fault
    retire(16'h1000, 0, 0, 0, 0, 0, "R1");
    retire(16'h1004, 0, 0, 0, 1, 0, "R1 plain fault");
    idle(); do_eret(); idle();

    // R2 / R3 / R1: fault swept over branch, slot and successor, both directions
    for (int tk = 0; tk < 2; tk++) begin
      for (int pos = 0; pos < 3; pos++) begin
        retire(16'h2000, 1, tk[0], 16'h3000, pos == 0, 0, "R3 branch fault");
        if (pos != 0) begin
          retire(16'h2004, 0, 0, 0, pos == 1, 0, "R2 slot fault");
          if (pos == 2) retire(tk ? 16'h3000 : 16'h2008, 0, 0, 0, 1, 0, "R1 after slot");
        end
        idle(); do_eret(); idle();
      end
    end

    // R6: interrupt held across the slot, both directions
    for (int tk = 0; tk < 2; tk++) begin
      retire(16'h4000, 1, tk[0], 16'h4800, 0, 1, "R6 irq on branch");
      retire(16'h4004, 0, 0, 0, 0, 0, "R6 irq after slot");
      idle(); do_eret(); idle();
    end

    // R7: interrupt at an ordinary boundary, and wrap at the top of the space
    retire(16'h5000, 0, 0, 0, 0, 1, "R7 plain irq");
    idle(); do_eret(); idle();
    retire(16'hFFF8, 1, 0, 16'h0040, 0, 1, "R6 wrap branch");
    retire(16'hFFFC, 0, 0, 0, 0, 0, "R7 wrap successor");
    idle(); do_eret(); idle();

    // R8 / R9: fault wins, interrupt kept through the handler, taken after return
    retire(16'h6000, 0, 0, 0, 1, 1, "R8 fault over irq");
    idle();
    retire(VEC, 0, 0, 0, 0, 1, "R9 masked in handler");
    retire(VEC + 16'd4, 0, 0, 0, 0, 0, "R9 masked in handler");
    do_eret(); idle();
    retire(16'h6000, 0, 0, 0, 0, 0, "R8 pending irq taken");
    idle(); do_eret(); idle();

    // R5: an offer during the redirect cycle is ignored
    retire(16'h7000, 0, 0, 0, 1, 0, "R5 setup fault");
    retire(16'h7004, 0, 0, 0, 1, 0, "R5 ignored");
    @(negedge clk);
    ret_valid = 0; ret_fault = 0;
    chk(!exc_taken && exc_epc == 16'h7000, "R5 offer ignored", exc_epc, 16'h7000);
    @(posedge clk);
    do_eret(); idle(); idle();

    chk(sb.size() == 0, "scoreboard drained", 16'(sb.size()), '0);
    finish_run();
  end
endmodule